// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor load/store port and a slower word-addressed memory. It holds a direct-mapped array of lines, each line four 32-bit words wide, with a valid bit, a dirty bit and a tag per line. A load or store that hits is answered in the same cycle. A miss stalls the processor while the block services it. If the victim line is dirty, the block first writes that line back to memory. It then refills the line from memory. The processor sees a hit once the refill completes.

Stores use write-back and write-allocate. A store that hits changes only the cached word and marks the line dirty. A store that misses first refills the line and then writes its data into it as a hit. Depending on the state of the victim, one access therefore costs zero, one or two line transfers on the memory side.

The processor holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` stable until it sees `cpu_ready` high at a rising clock edge. That edge completes the access, and `cpu_rdata` is valid in the same cycle. On the memory side, each word transfer is held until `mem_ready` is high at a rising edge, and `mem_rdata` is sampled in that cycle.

Top module: `dm_wb_cache`

## Requirements
- R1: The byte address is split as follows: bits 31..12 are the tag, bits 11..4 select one of 256 lines, and bits 3..2 select the word within the line. Bits 1..0 are neither stored nor compared, so addresses that differ only in those bits reach the same word.
- R2: An access hits only when the selected line is valid and its stored tag equals the address tag. An invalid line never hits, whatever its tag holds.
- R3: On a hit, `cpu_ready` is high in the first cycle of the request, and no memory request is issued for that access.
- R4: A store hit updates only the cached word and marks the line dirty, causing no memory traffic. A later load of that word returns the stored data.
- R5: A store miss reads the whole line from memory, then writes the store data into the cache. Memory keeps its old value for that word, and the line is dirty.
- R6: A miss whose victim line is invalid or clean issues exactly four reads and no writes.
- R7: A miss whose victim is dirty first issues four writes. The writes go to the victim's word addresses {old tag, index, offset} with offsets 0,1,2,3 in ascending order, and carry the latest data. Four reads of the new line follow, also with offsets 0..3 ascending. `mem_addr` is the byte address shifted right by two.
- R8: A refill caused by a load leaves the line clean, so evicting it later causes no write.
- R9: While a miss is serviced, `cpu_ready` stays low. Each memory request keeps its address, direction and write data stable until `mem_ready` is high.
- R10: Reset clears every valid and dirty bit. Directly after reset no memory request is pending, `cpu_ready` is low, and the first access misses.
- R11: With 4 lines of one word each, loads that alternate between word addresses 0 and 4 all miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Access request, held until accepted |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes at this edge |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = write back, 0 = refill read |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | 32 | Write-back data |
| mem_ready | input | 1 | Transfer completes at this edge |
| mem_rdata | input | 32 | Read data, sampled with mem_ready |

## Verification
The hardest case to reach from the ports is an eviction of a dirty line whose words were changed by stores at several different times. Only then does the written-back data show whether every store hit and every store-miss merge landed in the right word. The random stimulus therefore draws addresses from a few tags and a few line indexes, mixing loads and stores. Lines are evicted and dirtied again constantly while the memory stalls at random. Every write-back word is compared against the bench's record of the latest stored value. A second, reduced-geometry instance is driven with the alternating conflict pattern.

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 256,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic              cpu_ready,
  output logic [31:0]       cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata
);
  localparam int WA_W  = ADDR_W - 2;
  localparam int IDX_B = $clog2(LINES);
  localparam int OFS_B = $clog2(LINE_WORDS);
  localparam int TAG_W = WA_W - IDX_B - OFS_B;
  localparam int DEPTH = LINES * LINE_WORDS;
  localparam int DA_B  = IDX_B + OFS_B;
  localparam int CNT_W = (OFS_B > 0) ? OFS_B : 1;

  typedef enum logic [1:0] {S_IDLE, S_WBACK, S_FILL} st_t;

  st_t                st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [IDX_B-1:0]   miss_idx_q;
  logic [TAG_W-1:0]   miss_tag_q;
  logic [LINES-1:0]   valid_q, dirty_q;
  logic [TAG_W-1:0]   tag_q  [LINES];
  logic [31:0]        data_q [DEPTH];

  logic [WA_W-1:0]    wa;
  logic [TAG_W-1:0]   req_tag;
  logic [IDX_B-1:0]   req_idx;
  logic [DA_B-1:0]    req_da, line_da;
  logic               hit, last, unused_byte;
  logic [TAG_W+IDX_B-1:0] line_addr;

  assign wa          = cpu_addr[ADDR_W-1:2];
  assign unused_byte = ^cpu_addr[1:0];
  assign req_tag     = wa[WA_W-1 -: TAG_W];
  assign req_idx     = wa[OFS_B +: IDX_B];
  assign req_da      = wa[DA_B-1:0];
  assign hit         = valid_q[req_idx] && (tag_q[req_idx] == req_tag);
  assign last        = (cnt_q == CNT_W'(LINE_WORDS - 1));
  assign line_da     = DA_B'(miss_idx_q) * DA_B'(LINE_WORDS) + DA_B'(cnt_q);
  assign line_addr   = (st_q == S_WBACK) ? {tag_q[miss_idx_q], miss_idx_q}
                                         : {miss_tag_q, miss_idx_q};

  assign cpu_ready = cpu_req && (st_q == S_IDLE) && hit;
  assign cpu_rdata = data_q[req_da];
  assign mem_req   = (st_q != S_IDLE);
  assign mem_we    = (st_q == S_WBACK);
  assign mem_addr  = (WA_W'(line_addr) << OFS_B) | WA_W'(cnt_q);
  assign mem_wdata = data_q[line_da];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      cnt_q      <= '0;
      miss_idx_q <= '0;
      miss_tag_q <= '0;
      valid_q    <= '0;
      dirty_q    <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (cpu_req && !hit) begin
            miss_idx_q <= req_idx;
            miss_tag_q <= req_tag;
            cnt_q      <= '0;
            st_q       <= (valid_q[req_idx] && dirty_q[req_idx]) ? S_WBACK : S_FILL;
          end else if (cpu_req && cpu_we) begin
            dirty_q[req_idx] <= 1'b1;
          end
        end
        S_WBACK: if (mem_ready) begin
          cnt_q <= last ? '0 : cnt_q + 1'b1;
          if (last) st_q <= S_FILL;
        end
        S_FILL: if (mem_ready) begin
          cnt_q <= last ? '0 : cnt_q + 1'b1;
          if (last) begin
            valid_q[miss_idx_q] <= 1'b1;
            dirty_q[miss_idx_q] <= 1'b0;
            st_q                <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == S_FILL && mem_ready && last) tag_q[miss_idx_q] <= miss_tag_q;
    if (cpu_ready && cpu_we) data_q[req_da] <= cpu_wdata;
    else if (st_q == S_FILL && mem_ready) data_q[line_da] <= mem_rdata;
  end
endmodule

// File: rtl/dm_wb_cache_chk.sv
module dm_wb_cache_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-3:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ready
);
  localparam logic [ADDR_W-3:0] MASK = (ADDR_W-2)'(LINE_WORDS - 1);

  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req); // R3
  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req); // R3
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
  AST_BURST_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && ((mem_addr & MASK) != MASK)) |=> (mem_req && mem_addr == $past(mem_addr) + 1'b1 && mem_we == $past(mem_we))); // R7
  AST_BURST_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> ((mem_addr & MASK) == '0)); // R7
  AST_WRITES_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !(mem_req && mem_we)); // R7
endmodule

bind dm_wb_cache dm_wb_cache_chk #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/dm_wb_cache_bench.sv
module dm_wb_cache_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cpu_req = 0, cpu_we = 0, cpu_ready;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
  logic        mem_req, mem_we, mem_ready = 0;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = 0;

  dm_wb_cache u_dm_wb_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata));

  logic        s_req = 0, s_ready, s_mreq, s_mwe;
  logic [31:0] s_addr = 0, s_rdata, s_mwdata, s_mrdata;
  logic [29:0] s_maddr;
  assign s_mrdata = {s_maddr, 2'b11};

  dm_wb_cache #(.LINES(4), .LINE_WORDS(1)) u_dm_wb_cache_small (
    .clk(clk), .rst_n(rst_n), .cpu_req(s_req), .cpu_we(1'b0), .cpu_addr(s_addr),
    .cpu_wdata(32'h0), .cpu_ready(s_ready), .cpu_rdata(s_rdata),
    .mem_req(s_mreq), .mem_we(s_mwe), .mem_addr(s_maddr), .mem_wdata(s_mwdata),
    .mem_ready(1'b1), .mem_rdata(s_mrdata));

  int checks = 0, fails = 0;
  logic [31:0] bmem [int unsigned];
  logic [31:0] gold [int unsigned];
  logic        rv [256];
  logic        rd [256];
  logic [19:0] rt [256];
  logic [29:0] log_a [16];
  logic        log_w [16];
  logic [31:0] log_d [16];
  int          log_n = 0;

  function automatic logic [31:0] init_val(int unsigned w);
    return w * 32'h9E3779B1 ^ 32'hA5C30F1E;
  endfunction
  function automatic logic [31:0] mem_rd(int unsigned w);
    return bmem.exists(w) ? bmem[w] : init_val(w);
  endfunction
  function automatic logic [31:0] gold_rd(int unsigned w);
    return gold.exists(w) ? gold[w] : init_val(w);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    mem_ready = ($urandom_range(0, 3) != 0);
    mem_rdata = mem_rd(int'(mem_addr));
    #5;
    if (rst_n && mem_req && mem_ready && log_n < 16) begin
      log_a[log_n] = mem_addr;
      log_w[log_n] = mem_we;
      log_d[log_n] = mem_wdata;
      if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
      log_n++;
    end
  end

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d, input string rq);
    logic [7:0]  idx = a[11:4];
    logic [19:0] tg = a[31:12];
    logic [19:0] vt = rt[a[11:4]];
    int unsigned w = int'(a[31:2]);
    bit exp_hit = rv[idx] && rt[idx] == tg;
    bit exp_wb = !exp_hit && rd[idx];
    bit first = 1;
    int n, bad = 0;
    logic [29:0] ea;
    logic [31:0] rdv;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; log_n = 0;
    for (int c = 0; ; c++) begin
      #5;
      if (cpu_ready || c > 500) break;
      first = 0;
      @(negedge clk);
    end
    rdv = cpu_rdata;
    @(negedge clk);
    cpu_req = 0;
    chk(first == exp_hit, {rq, exp_hit ? " R3 hit ready" : " R9 miss stall"}, 32'(first), 32'(exp_hit));
    if (!we) chk(rdv == gold_rd(w), {rq, " R4 load data"}, rdv, gold_rd(w));
    n = exp_hit ? 0 : (exp_wb ? 8 : 4);
    chk(log_n == n, {rq, " R6 transfer count"}, 32'(log_n), 32'(n));
    for (int i = 0; i < n && i < log_n; i++) begin
      if (exp_wb && i < 4) begin
        ea = {vt, idx, 2'(i)};
        if (!log_w[i] || log_a[i] != ea || log_d[i] != gold_rd(int'(ea))) bad++;
      end else begin
        ea = {tg, idx, 2'(exp_wb ? i - 4 : i)};
        if (log_w[i] || log_a[i] != ea) bad++;
      end
    end
    chk(bad == 0, {rq, " R7 transfer order/data"}, 32'(bad), 32'd0);
    if (!exp_hit) begin rv[idx] = 1; rt[idx] = tg; rd[idx] = 0; end
    if (we) begin rd[idx] = 1; gold[w] = d; end
  endtask

  task automatic small_access(input logic [31:0] a);
    bit first = 1;
    logic [31:0] rdv;
    @(negedge clk);
    s_req = 1; s_addr = a;
    for (int c = 0; ; c++) begin
      #5;
      if (s_ready || c > 50) break;
      first = 0;
      @(negedge clk);
    end
    rdv = s_rdata;
    @(negedge clk);
    s_req = 0;
    chk(!first, "R11 conflict miss", 32'(first), 32'd0);
    chk(rdv == {a[31:2], 2'b11}, "R11 conflict data", rdv, {a[31:2], 2'b11});
  endtask

  bit done = 0;
  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin rv[i] = 0; rd[i] = 0; rt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #5;
    chk(!cpu_ready && !mem_req, "R10 reset state", {30'd0, cpu_ready, mem_req}, 32'd0);
    access(0, 32'h0000_0000, 0, "R10 first access");
    access(0, 32'h0000_0050, 0, "R2 invalid line");
    access(0, 32'h0000_0003, 0, "R1 byte bits");
    access(0, 32'h0000_0008, 0, "R1 word select");
    access(1, 32'h0000_0004, 32'hCAFE_0001, "R4 store hit");
    access(0, 32'h0000_0005, 0, "R4 reload");
    access(0, 32'h0000_1000, 0, "R7 dirty evict");
    access(0, 32'h0000_0010, 0, "R6 clean fill");
    access(0, 32'h0000_1010, 0, "R8 clean evict");
    access(1, 32'h0000_2028, 32'h1234_5678, "R5 store miss");
    chk(mem_rd(32'h80A) == init_val(32'h80A), "R5 memory stale", mem_rd(32'h80A), init_val(32'h80A));
    access(0, 32'h0000_2028, 0, "R5 merged data");
    access(0, 32'h0000_4020, 0, "R5 dirty after merge");
    for (int k = 0; k < 500; k++) begin
      logic [31:0] a = {18'd0, 2'($urandom_range(0, 3)), 6'd0, 2'($urandom_range(0, 3)),
                        2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
      access($urandom_range(0, 1) == 1, a, $urandom, "R7 random");
    end
    for (int k = 0; k < 8; k++) small_access((k % 2 == 0) ? 32'd0 : 32'd16);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule